// File: doc/BRIEF.md
# Permission-Split Direct-Mapped Translation Buffer

This block translates a virtual address into a physical address for one of three access kinds: instruction fetch, data load or data store. It is direct-mapped. One array holds the physical page base for each slot. Three tag arrays, one per access kind, sit beside it. A tag array holds the page tag of a slot only when its kind of access was allowed at the time the slot was filled. Otherwise it holds an all-ones value that never matches. A hit therefore means the permission check has already passed, and the hit path compares tags and nothing more.

On a miss the block stalls the requester and asks an external page-table walker for the entry. When the entry comes back, the block first folds the privilege mode into the permission bits and then checks them against the access kind. If the check passes, the block fills all four arrays and the retried lookup hits. If it fails, the block completes the request with an access fault, reports the fault kind and latches the faulting virtual address. A flush invalidates every slot of all three tag arrays in a single cycle.

A requester holds `req_valid`, `req_kind`, `req_super` and `req_vaddr` steady until `req_ready` is seen high at a clock edge. The result on `resp_*` is valid in that cycle.

Top module: `ptlb_top`

## Requirements
- R1: After reset, no request is ready and no walk is requested, `bad_vaddr` reads zero, and every slot misses for every access kind.
- R2: The slot index is `req_vaddr[PG_SHIFT +: log2(ENTRIES)]`. A hit needs the tag of the requested kind to equal `req_vaddr` with its low `PG_SHIFT` bits cleared. Two pages whose page numbers differ by a multiple of ENTRIES share a slot, and each evicts the other.
- R3: On a hit, `req_ready` rises in the same cycle as the request. `resp_paddr` is the entry's physical page number (PTE bits above `PPN_SHIFT`) followed by the low `PG_SHIFT` bits of `req_vaddr`.
- R4: The access kind is encoded on `req_kind` as 0 load, 1 store and 2 fetch; the value 3 acts as a load. An access is granted only if the effective permission has bit 0 (valid) set and also the kind's own bit: bit 1 for a load, bit 2 for a store, bit 3 for a fetch.
- R5: When `req_super` is 1, the effective permission takes PTE bits 6:4 into positions 3:1 and ignores PTE bits 3:1. When it is 0, the effective permission is PTE bits 3:1. In both modes, bit 0 is PTE bit 0.
- R6: A denied access completes with `req_ready` and `resp_fault` both high. `resp_fkind` is 1 for a load, 2 for a store and 3 for a fetch, and reads 0 when there is no fault. `bad_vaddr` takes the faulting `req_vaddr`.
- R7: A granted refill writes the tag of each kind whose effective bit is set and writes all-ones into the others. An access of another kind to the same page hits without a walk exactly when its own bit was set. If that bit was not set, the access walks again.
- R8: One cycle of `flush` makes every slot miss for every kind, and it takes priority over a refill in the same cycle.
- R9: On a miss, `req_ready` stays low and `walk_req_valid` stays high with `walk_req_vaddr` equal to `req_vaddr` until `walk_rsp_valid` is seen. Only one walk is outstanding at a time.
- R10: A walker response of all zeros counts as a denied access and faults with the kind of the current request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all slots |
| req_valid | input | 1 | Translation request present |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_super | input | 1 | Supervisor mode for this request |
| req_vaddr | input | VA_W | Virtual address |
| req_ready | output | 1 | Request completes this cycle |
| resp_paddr | output | PA_W | Translated physical address |
| resp_fault | output | 1 | Access fault |
| resp_fkind | output | 2 | Fault kind: 0 none, 1 load, 2 store, 3 fetch |
| bad_vaddr | output | VA_W | Last faulting virtual address |
| walk_req_valid | output | 1 | Walk requested |
| walk_req_vaddr | output | VA_W | Address to walk |
| walk_rsp_valid | input | 1 | Walker result present |
| walk_rsp_pte | input | PTE_W | Walker result; zero means no entry |

## Verification
The bench builds the block with 8 slots, 4-bit page offsets, 16-bit virtual addresses and a 20-bit entry. This brings every combination of the seven low permission bits, in both privilege modes, within a short run. Each granted fill is followed by accesses of all three kinds to the same page, so the tag-split rule is checked for every permission pattern. With only 8 slots, aliasing pages are cheap to build, and every page offset can be swept against a hit.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;

    // access kinds; value 3 is folded onto load
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_LOAD  = 2'd1,
        FLT_STORE = 2'd2,
        FLT_FETCH = 2'd3
    } flt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WALK  = 2'd1,
        ST_FAULT = 2'd2
    } st_e;

    localparam int PERM_W  = 7;   // valid + user rwx + supervisor rwx
    localparam int SUP_SHR = 3;

    typedef struct packed {
        logic ux;
        logic uw;
        logic ur;
        logic vld;
    } perm_t;

    function automatic acc_e norm_kind(input logic [1:0] k);
        return (k == 2'd3) ? ACC_LOAD : acc_e'(k);
    endfunction

    function automatic perm_t fold_perm(input logic [PERM_W-1:0] raw, input logic sup);
        logic [PERM_W-1:0] rwx;
        rwx = sup ? ((raw & 7'h7E) >> SUP_SHR) : (raw & 7'h0E);
        return perm_t'({rwx[3:1], raw[0]});
    endfunction

    function automatic flt_e fault_of(input acc_e k);
        case (k)
            ACC_STORE: return FLT_STORE;
            ACC_FETCH: return FLT_FETCH;
            default:   return FLT_LOAD;
        endcase
    endfunction

endpackage

// File: rtl/ptlb_bank.sv
module ptlb_bank #(
    parameter int              ENTRIES = 256,
    parameter int              WIDTH   = 32,
    parameter logic            INIT_ONES = 1'b1,
    localparam int             IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [WIDTH-1:0] rdata
);
    localparam logic [WIDTH-1:0] INIT = INIT_ONES ? '1 : '0;

    logic [WIDTH-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= INIT;
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/ptlb_perm_eval.sv
module ptlb_perm_eval
    import ptlb_pkg::*;
(
    input  logic [PERM_W-1:0] raw,
    input  logic              sup,
    input  acc_e              kind,
    output logic              grant,
    output logic [2:0]        kind_ok
);
    perm_t eff;
    logic  need;

    always_comb begin
        eff = fold_perm(raw, sup);
        kind_ok[ACC_LOAD]  = eff.ur;
        kind_ok[ACC_STORE] = eff.uw;
        kind_ok[ACC_FETCH] = eff.ux;
        case (kind)
            ACC_STORE: need = eff.uw;
            ACC_FETCH: need = eff.ux;
            default:   need = eff.ur;
        endcase
        grant = eff.vld && need;
    end
endmodule

// File: rtl/ptlb_top.sv
module ptlb_top
    import ptlb_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PG_SHIFT  = 12,
    parameter int ENTRIES   = 256,
    parameter int PTE_W     = 32,
    parameter int PPN_SHIFT = 10,
    localparam int IDX_W    = $clog2(ENTRIES),
    localparam int PPN_W    = PTE_W - PPN_SHIFT,
    localparam int PA_W     = PPN_W + PG_SHIFT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic             req_super,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             req_ready,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             resp_fault,
    output logic [1:0]       resp_fkind,
    output logic [VA_W-1:0]  bad_vaddr,
    output logic             walk_req_valid,
    output logic [VA_W-1:0]  walk_req_vaddr,
    input  logic             walk_rsp_valid,
    input  logic [PTE_W-1:0] walk_rsp_pte
);
    st_e             state;
    flt_e            flt_q;
    acc_e            kind;
    logic [IDX_W-1:0] idx;
    logic [VA_W-1:0] page_tag;
    logic [VA_W-1:0] tag_rd [3];
    logic [PA_W-1:0] base_rd;
    logic            hit;
    logic            grant;
    logic [2:0]      kind_ok;
    logic            fill;

    assign kind     = norm_kind(req_kind);
    assign idx      = req_vaddr[PG_SHIFT +: IDX_W];
    assign page_tag = {req_vaddr[VA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
    assign hit      = (tag_rd[kind] == page_tag);

    ptlb_perm_eval u_perm (
        .raw     (walk_rsp_pte[PERM_W-1:0]),
        .sup     (req_super),
        .kind    (kind),
        .grant   (grant),
        .kind_ok (kind_ok)
    );

    assign fill = (state == ST_WALK) && walk_rsp_valid && grant;

    for (genvar k = 0; k < 3; k++) begin : g_tag
        ptlb_bank #(.ENTRIES(ENTRIES), .WIDTH(VA_W), .INIT_ONES(1'b1)) u_tag (
            .clk   (clk),
            .rst   (rst),
            .clr   (flush),
            .we    (fill),
            .widx  (idx),
            .wdata (kind_ok[k] ? page_tag : {VA_W{1'b1}}),
            .ridx  (idx),
            .rdata (tag_rd[k])
        );
    end

    ptlb_bank #(.ENTRIES(ENTRIES), .WIDTH(PA_W), .INIT_ONES(1'b0)) u_base (
        .clk   (clk),
        .rst   (rst),
        .clr   (1'b0),
        .we    (fill && !flush),
        .widx  (idx),
        .wdata ({walk_rsp_pte[PTE_W-1:PPN_SHIFT], {PG_SHIFT{1'b0}}}),
        .ridx  (idx),
        .rdata (base_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            flt_q     <= FLT_NONE;
            bad_vaddr <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid && !hit) state <= ST_WALK;
                ST_WALK: if (walk_rsp_valid) begin
                    if (grant) begin
                        state <= ST_IDLE;
                    end else begin
                        state     <= ST_FAULT;
                        flt_q     <= fault_of(kind);
                        bad_vaddr <= req_vaddr;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready      = req_valid && (((state == ST_IDLE) && hit) || (state == ST_FAULT));
    assign resp_fault     = (state == ST_FAULT);
    assign resp_fkind     = resp_fault ? flt_q : FLT_NONE;
    assign resp_paddr     = base_rd | {{(PA_W-PG_SHIFT){1'b0}}, req_vaddr[PG_SHIFT-1:0]};
    assign walk_req_valid = (state == ST_WALK);
    assign walk_req_vaddr = req_vaddr;
endmodule

// File: rtl/ptlb_checker.sv
module ptlb_checker #(
    parameter int VA_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            flush,
    input logic            req_valid,
    input logic [1:0]      req_kind,
    input logic [VA_W-1:0] req_vaddr,
    input logic            req_ready,
    input logic            resp_fault,
    input logic [1:0]      resp_fkind,
    input logic [VA_W-1:0] bad_vaddr,
    input logic            walk_req_valid,
    input logic            walk_rsp_valid
);
    p_walk_held_r9: assert property (@(posedge clk) disable iff (rst)
        walk_req_valid && !walk_rsp_valid |=> walk_req_valid);

    p_stall_in_walk_r9: assert property (@(posedge clk) disable iff (rst)
        walk_req_valid |-> !req_ready);

    p_ready_needs_valid_r9: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> req_valid);

    p_bad_addr_r6: assert property (@(posedge clk) disable iff (rst)
        req_ready && resp_fault |-> bad_vaddr == req_vaddr);

    p_fault_kind_r6: assert property (@(posedge clk) disable iff (rst)
        req_ready && resp_fault |->
            resp_fkind == ((req_kind == 2'd1) ? 2'd2 : (req_kind == 2'd2) ? 2'd3 : 2'd1));

    p_no_kind_without_fault_r6: assert property (@(posedge clk) disable iff (rst)
        !resp_fault |-> resp_fkind == 2'd0);

    p_flush_miss_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> !(req_ready && !resp_fault));
endmodule

bind ptlb_top ptlb_checker #(.VA_W(VA_W)) i_chk (
    .clk            (clk),
    .rst            (rst),
    .flush          (flush),
    .req_valid      (req_valid),
    .req_kind       (req_kind),
    .req_vaddr      (req_vaddr),
    .req_ready      (req_ready),
    .resp_fault     (resp_fault),
    .resp_fkind     (resp_fkind),
    .bad_vaddr      (bad_vaddr),
    .walk_req_valid (walk_req_valid),
    .walk_rsp_valid (walk_rsp_valid)
);

// File: tb/test_ptlb_top.sv
module test_ptlb_top;
    localparam int CLK_PERIOD = 10;
    localparam int VA_W = 16, PG_SHIFT = 4, ENTRIES = 8, PTE_W = 20, PPN_SHIFT = 8;
    localparam int PA_W = PTE_W - PPN_SHIFT + PG_SHIFT;

    logic clk = 1'b0, rst = 1'b1, flush = 1'b0;
    logic req_valid = 1'b0, req_super = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic [VA_W-1:0] req_vaddr = '0;
    logic req_ready, resp_fault, walk_req_valid;
    logic [PA_W-1:0] resp_paddr;
    logic [1:0] resp_fkind;
    logic [VA_W-1:0] bad_vaddr, walk_req_vaddr;
    logic walk_rsp_valid = 1'b0;
    logic [PTE_W-1:0] walk_rsp_pte = '0;

    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptlb_top #(.VA_W(VA_W), .PG_SHIFT(PG_SHIFT), .ENTRIES(ENTRIES),
               .PTE_W(PTE_W), .PPN_SHIFT(PPN_SHIFT)) i_ptlb_top (
        .clk(clk), .rst(rst), .flush(flush), .req_valid(req_valid),
        .req_kind(req_kind), .req_super(req_super), .req_vaddr(req_vaddr),
        .req_ready(req_ready), .resp_paddr(resp_paddr), .resp_fault(resp_fault),
        .resp_fkind(resp_fkind), .bad_vaddr(bad_vaddr),
        .walk_req_valid(walk_req_valid), .walk_req_vaddr(walk_req_vaddr),
        .walk_rsp_valid(walk_rsp_valid), .walk_rsp_pte(walk_rsp_pte));

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // result of the last access
    logic            a_walked, a_fault;
    logic [1:0]      a_fkind;
    logic [PA_W-1:0] a_paddr;

    task automatic access(input logic [1:0] k, input logic sup,
                          input logic [VA_W-1:0] va, input logic [PTE_W-1:0] pte);
        bit sent = 0;
        req_valid = 1'b1; req_kind = k; req_super = sup; req_vaddr = va;
        a_walked = 0;
        forever begin
            #1;
            if (req_ready) begin
                a_fault = resp_fault; a_fkind = resp_fkind; a_paddr = resp_paddr;
                @(posedge clk);
                @(negedge clk);
                req_valid = 1'b0;
                break;
            end else if (walk_req_valid && !sent) begin
                check("R9 walk address", 32'(walk_req_vaddr), 32'(va));
                a_walked = 1; sent = 1;
                walk_rsp_valid = 1'b1; walk_rsp_pte = pte;
                @(posedge clk);
                @(negedge clk);
                walk_rsp_valid = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    function automatic logic [3:0] eff(input logic [6:0] raw, input logic sup);
        logic [2:0] rwx = sup ? raw[6:4] : raw[3:1];
        return {rwx, raw[0]};
    endfunction

    function automatic logic bit_of(input logic [3:0] e, input int k);
        return (k == 1) ? e[2] : (k == 2) ? e[3] : e[1];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [PTE_W-1:0] pte;
        logic [VA_W-1:0]  va;
        logic [3:0]       e;
        logic             ok;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check("R1 ready after reset", 32'(req_ready), 0);
        check("R1 walk after reset", 32'(walk_req_valid), 0);
        check("R1 bad_vaddr after reset", 32'(bad_vaddr), 0);
        @(negedge clk);

        // R1/R3: first access walks, then hits across every offset
        pte = {12'hA5C, 8'h0F};
        access(2'd0, 0, 16'h1230, pte);
        check("R1 first access walks", 32'(a_walked), 1);
        for (int off = 0; off < 16; off++) begin
            access(2'd0, 0, 16'h1230 | 16'(off), pte);
            check("R3 hit no walk", 32'(a_walked), 0);
            check("R3 paddr", 32'(a_paddr), 32'({12'hA5C, 4'(off)}));
        end

        // R2: aliasing pages (page numbers differ by ENTRIES) evict each other
        access(2'd0, 0, 16'h1230 + 16'(ENTRIES << PG_SHIFT), {12'h111, 8'h0F});
        check("R2 alias walks", 32'(a_walked), 1);
        check("R2 alias paddr", 32'(a_paddr), 32'({12'h111, 4'h0}));
        access(2'd0, 0, 16'h1234, pte);
        check("R2 evicted page walks again", 32'(a_walked), 1);
        access(2'd0, 0, 16'h1244, {12'h222, 8'h0F});
        access(2'd0, 0, 16'h1235, pte);
        check("R2 neighbour slot keeps entry", 32'(a_walked), 0);
        access(2'd3, 0, 16'h1235, pte);
        check("R4 kind 3 acts as load", 32'(a_walked), 0);

        // R8: flush
        do_flush();
        access(2'd0, 0, 16'h1235, pte);
        check("R8 miss after flush", 32'(a_walked), 1);

        // R10: zero entry faults per kind
        for (int k = 0; k < 3; k++) begin
            va = 16'h4000 + 16'(k * 16'h0110);
            access(2'(k), 0, va, '0);
            check("R10 zero entry faults", 32'(a_fault), 1);
            check("R10 fault kind", 32'(a_fkind), 32'(k + 1));
            check("R6 bad_vaddr", 32'(bad_vaddr), 32'(va));
        end

        // R4/R5/R6/R7: all permission patterns, both modes
        for (int sup = 0; sup < 2; sup++) begin
            for (int p = 0; p < 128; p++) begin
                int k = p % 3;
                do_flush();
                va  = 16'(p * 16'h0101 + sup * 16'h0800) ^ 16'h0003;
                pte = {12'(p * 7 + 1), 1'b0, 7'(p)};
                e   = eff(7'(p), 1'(sup));
                ok  = e[0] && bit_of(e, k);
                access(2'(k), 1'(sup), va, pte);
                check(sup ? "R5 grant supervisor" : "R4 grant user", 32'(!a_fault), 32'(ok));
                if (!ok) begin
                    check("R6 fault kind", 32'(a_fkind), 32'(k + 1));
                    check("R6 bad_vaddr", 32'(bad_vaddr), 32'(va));
                end else begin
                    check("R3 paddr after fill", 32'(a_paddr), 32'({12'(p * 7 + 1), va[3:0]}));
                    for (int j = 0; j < 3; j++) begin
                        access(2'(j), 1'(sup), va, pte);
                        check("R7 other kind walks iff denied", 32'(a_walked), 32'(!bit_of(e, j)));
                        check("R7 other kind fault", 32'(a_fault), 32'(!bit_of(e, j)));
                    end
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule